// File: doc/BRIEF.md
# Frequency-Hopping Numerically Controlled Oscillator

This block produces a single digital sine carrier whose frequency can change from one clock to the next. A bank of phase-increment registers, at most sixteen deep with the depth set by a parameter, is loaded through a memory-mapped slave port that follows the usual address/write/read convention with a fixed read latency. A hardware select input chooses which register feeds a 32-bit phase accumulator. An external hop sequencer switches among preset frequencies by moving that select. The block does not need to be reprogrammed for a hop.

The accumulator is never reloaded when the select changes. Only the step it adds changes, so the carrier phase stays continuous across every hop. The top bits of the phase address a computed table of signed 16-bit sine samples, and the sample is registered one cycle behind the phase.

Top module: `hop_nco`

## Requirements
- R1: Reset, asynchronous and active low, clears the accumulator, every increment register, `phase_out`, `sample_out` and `bus_readdata` to zero.
- R2: A write whose address is below `NUM_REGS` stores `bus_writedata` in the register with that index. A later read of the same address returns that value.
- R3: A write whose address is `NUM_REGS` or above changes no register. A read of such an address returns zero.
- R4: A read returns data in the cycle after `bus_read` is sampled high. The data is the register contents before any write sampled in the same cycle. In a cycle that follows one with `bus_read` low, `bus_readdata` is zero.
- R5: At each rising clock edge the accumulator adds the register chosen by `hop_sel` as sampled at that edge. A new select value therefore steers the very next update.
- R6: A change of `hop_sel` never reloads or clears the accumulator. The phase wraps modulo 2^32, so no hop causes a phase jump beyond the normal step.
- R7: A `hop_sel` value of `NUM_REGS` or above selects a zero increment, and the phase holds.
- R8: A write to the register that is currently selected is used by the accumulator from the clock edge that follows the edge capturing the write.
- R9: `sample_out` equals round(32767 * sin(2*pi*k / 2^LUT_AW)), where k is the top `LUT_AW` bits of the phase that `phase_out` showed one cycle earlier. Full negative scale (-32768) never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | BUS_AW (4) | Register index for bus writes and reads |
| bus_write | input | 1 | Write strobe |
| bus_writedata | input | PHASE_W (32) | Increment value to store |
| bus_read | input | 1 | Read strobe |
| bus_readdata | output | PHASE_W (32) | Read data, one cycle after the strobe |
| hop_sel | input | BUS_AW (4) | Active increment register select |
| phase_out | output | PHASE_W (32) | Current accumulator phase |
| sample_out | output | AMP_W (16) | Signed sine sample |

## Verification
The bench builds the block with `NUM_REGS` set to 6 instead of the power of two. Addresses 6 to 15 are then legal bus values that lie outside the bank, so ignored writes, zero reads and zero-step select values can all be driven through the ports. `LUT_AW` stays at 8 and `PHASE_W` at 32. With those values, increments near 2^31 and negative-looking increments make the accumulator wrap within a few cycles, and every sample can be predicted from a closed-form sine.

// File: rtl/hop_nco_pkg.sv
package hop_nco_pkg;

    localparam int MAX_REGS  = 16;
    localparam int PHASE_W_D = 32;
    localparam real TWO_PI   = 6.283185307179586;

    // Rounded sine code for table entry idx out of depth, peak = 2^(amp_w-1)-1
    function automatic int sine_code(input int idx, input int depth, input int amp_w);
        real peak;
        real ang;
        peak = real'((1 << (amp_w - 1)) - 1);
        ang  = TWO_PI * real'(idx) / real'(depth);
        return $rtoi($floor(peak * $sin(ang) + 0.5));
    endfunction

endpackage

// File: rtl/hop_inc_bank.sv
module hop_inc_bank #(
    parameter int NUM_REGS = 16,
    parameter int BUS_AW   = 4,
    parameter int DATA_W   = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic                             rd_en,
    input  logic [BUS_AW-1:0]                addr,
    input  logic [DATA_W-1:0]                wdata,
    input  logic [BUS_AW-1:0]                sel,
    output logic [DATA_W-1:0]                rdata,
    output logic [DATA_W-1:0]                sel_inc,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_out
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic [DATA_W-1:0]               rdata;
    } bank_state_t;

    bank_state_t st_d, st_q;

    // Next state: decoded writes, registered read port (zero when idle)
    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_en && (addr == BUS_AW'(i))) begin
                st_d.rdata = st_q.regs[i];
            end
            if (wr_en && (addr == BUS_AW'(i))) begin
                st_d.regs[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Select path: out-of-range select yields a zero step
    always_comb begin
        sel_inc = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel == BUS_AW'(i)) begin
                sel_inc = st_q.regs[i];
            end
        end
    end

    assign rdata    = st_q.rdata;
    assign regs_out = st_q.regs;

endmodule

// File: rtl/hop_phase_acc.sv
module hop_phase_acc #(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] step,
    output logic [PHASE_W-1:0] phase
);

    typedef struct packed {
        logic [PHASE_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;

    // Continuous accumulation, wraps modulo 2^PHASE_W; never reloaded on a hop
    always_comb begin
        st_d     = st_q;
        st_d.acc = st_q.acc + step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.acc;

endmodule

// File: rtl/hop_sine_lut.sv
module hop_sine_lut #(
    parameter int LUT_AW = 8,
    parameter int AMP_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LUT_AW-1:0]        idx,
    output logic signed [AMP_W-1:0]  sample
);

    localparam int DEPTH = 1 << LUT_AW;

    logic signed [AMP_W-1:0] table_w [DEPTH];

    // Table contents computed at elaboration
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam int CODE = hop_nco_pkg::sine_code(i, DEPTH, AMP_W);
        assign table_w[i] = AMP_W'(CODE);
    end

    typedef struct packed {
        logic signed [AMP_W-1:0] smp;
    } lut_state_t;

    lut_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.smp = table_w[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample = st_q.smp;

endmodule

// File: rtl/hop_nco.sv
module hop_nco #(
    parameter int NUM_REGS = 16,
    parameter int BUS_AW   = 4,
    parameter int PHASE_W  = hop_nco_pkg::PHASE_W_D,
    parameter int LUT_AW   = 8,
    parameter int AMP_W    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [BUS_AW-1:0]        bus_addr,
    input  logic                     bus_write,
    input  logic [PHASE_W-1:0]       bus_writedata,
    input  logic                     bus_read,
    output logic [PHASE_W-1:0]       bus_readdata,
    input  logic [BUS_AW-1:0]        hop_sel,
    output logic [PHASE_W-1:0]       phase_out,
    output logic signed [AMP_W-1:0]  sample_out
);

    localparam int IDX_LSB = PHASE_W - LUT_AW;

    logic [PHASE_W-1:0]                sel_inc;
    logic [NUM_REGS-1:0][PHASE_W-1:0]  bank_regs;
    logic [PHASE_W-1:0]                acc_phase;

    hop_inc_bank #(
        .NUM_REGS (NUM_REGS),
        .BUS_AW   (BUS_AW),
        .DATA_W   (PHASE_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_write),
        .rd_en    (bus_read),
        .addr     (bus_addr),
        .wdata    (bus_writedata),
        .sel      (hop_sel),
        .rdata    (bus_readdata),
        .sel_inc  (sel_inc),
        .regs_out (bank_regs)
    );

    hop_phase_acc #(
        .PHASE_W (PHASE_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (sel_inc),
        .phase (acc_phase)
    );

    hop_sine_lut #(
        .LUT_AW (LUT_AW),
        .AMP_W  (AMP_W)
    ) u_lut (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx    (acc_phase[PHASE_W-1:IDX_LSB]),
        .sample (sample_out)
    );

    assign phase_out = acc_phase;

endmodule

// File: rtl/hop_nco_chk.sv
module hop_nco_chk #(
    parameter int NUM_REGS = 16,
    parameter int BUS_AW   = 4,
    parameter int PHASE_W  = 32,
    parameter int AMP_W    = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [BUS_AW-1:0]                bus_addr,
    input  logic                             bus_write,
    input  logic [PHASE_W-1:0]               bus_writedata,
    input  logic                             bus_read,
    input  logic [PHASE_W-1:0]               bus_readdata,
    input  logic [BUS_AW-1:0]                hop_sel,
    input  logic [PHASE_W-1:0]               phase_out,
    input  logic signed [AMP_W-1:0]          sample_out,
    input  logic [PHASE_W-1:0]               sel_inc,
    input  logic [NUM_REGS-1:0][PHASE_W-1:0] bank_regs
);

    localparam logic [BUS_AW:0] NREG = (BUS_AW + 1)'(NUM_REGS);

    logic addr_in, sel_in;
    assign addr_in = ({1'b0, bus_addr} < NREG);
    assign sel_in  = ({1'b0, hop_sel} < NREG);

    // R2: in-range write lands in the addressed register
    assert_write_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_write && addr_in) |=> (bank_regs[$past(bus_addr)] == $past(bus_writedata)));

    // R3: out-of-range write leaves the bank untouched
    assert_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_write && !addr_in) |=> $stable(bank_regs));

    // R3: out-of-range read returns zero
    assert_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_read && !addr_in) |=> (bus_readdata == '0));

    // R4: no read strobe, zero read data next cycle
    assert_idle_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_read |=> (bus_readdata == '0));

    // R5 R6: phase advances by exactly the selected step, modulo 2^PHASE_W
    assert_phase_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (phase_out == PHASE_W'($past(phase_out) + $past(sel_inc))));

    // R7: out-of-range select holds the phase
    assert_sel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_in |=> $stable(phase_out));

    // R9: negative full scale never produced
    assert_amp_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sample_out != {1'b1, {(AMP_W-1){1'b0}}});

endmodule

bind hop_nco hop_nco_chk #(
    .NUM_REGS (NUM_REGS),
    .BUS_AW   (BUS_AW),
    .PHASE_W  (PHASE_W),
    .AMP_W    (AMP_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_write     (bus_write),
    .bus_writedata (bus_writedata),
    .bus_read      (bus_read),
    .bus_readdata  (bus_readdata),
    .hop_sel       (hop_sel),
    .phase_out     (phase_out),
    .sample_out    (sample_out),
    .sel_inc       (sel_inc),
    .bank_regs     (bank_regs)
);

// File: tb/sim_hop_nco.sv
module sim_hop_nco;

    localparam int N     = 6;
    localparam int AW    = 4;
    localparam int PW    = 32;
    localparam int LAW   = 8;
    localparam int AMPW  = 16;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [AW-1:0]          bus_addr = '0;
    logic                   bus_write = 1'b0;
    logic [PW-1:0]          bus_writedata = '0;
    logic                   bus_read = 1'b0;
    logic [PW-1:0]          bus_readdata;
    logic [AW-1:0]          hop_sel = '0;
    logic [PW-1:0]          phase_out;
    logic signed [AMPW-1:0] sample_out;

    always #2.5 clk = ~clk;   // 200 MHz

    hop_nco #(
        .NUM_REGS (N),
        .BUS_AW   (AW),
        .PHASE_W  (PW),
        .LUT_AW   (LAW),
        .AMP_W    (AMPW)
    ) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_write     (bus_write),
        .bus_writedata (bus_writedata),
        .bus_read      (bus_read),
        .bus_readdata  (bus_readdata),
        .hop_sel       (hop_sel),
        .phase_out     (phase_out),
        .sample_out    (sample_out)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_tag = "R5";
    bit    done = 1'b0;

    typedef struct {
        logic [PW-1:0] ph;
        int            smp;
    } exp_t;

    exp_t          exp_q[$];
    logic [PW-1:0] m_acc;
    logic [PW-1:0] m_bank [N];

    function automatic int exp_sine(input logic [PW-1:0] ph);
        int  k;
        real a;
        k = int'(ph >> (PW - LAW));
        a = 6.283185307179586 * real'(k) / real'(1 << LAW);
        return $rtoi($floor(32767.0 * $sin(a) + 0.5));
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Reference model: pushes the expected outputs produced by each edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_acc = '0;
            for (int i = 0; i < N; i++) m_bank[i] = '0;
            exp_q.delete();
        end else begin
            exp_t          e;
            logic [PW-1:0] stp;
            stp   = (int'(hop_sel) < N) ? m_bank[hop_sel] : '0;
            e.smp = exp_sine(m_acc);
            m_acc = m_acc + stp;
            if (bus_write && int'(bus_addr) < N) m_bank[bus_addr] = bus_writedata;
            e.ph  = m_acc;
            exp_q.push_back(e);
        end
    end

    // Monitor: compares the design's outputs against the queue
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            int   d;
            e = exp_q.pop_front();
            check(phase_out == e.ph, {cur_tag, " phase"}, phase_out, e.ph);
            d = int'(sample_out) - e.smp;
            check(d >= -1 && d <= 1, "R9 sample", longint'(sample_out), longint'(e.smp));
        end
    end

    task automatic bus_wr(input int a, input logic [PW-1:0] v);
        bus_addr      = AW'(a);
        bus_writedata = v;
        bus_write     = 1'b1;
        @(negedge clk);
        bus_write     = 1'b0;
    endtask

    task automatic bus_rd(input int a, input logic [PW-1:0] exp, input string req);
        bus_addr = AW'(a);
        bus_read = 1'b1;
        @(negedge clk);
        check(bus_readdata == exp, req, bus_readdata, exp);
        bus_read = 1'b0;
    endtask

    task automatic hop(input int s, input int cycles, input string tag);
        cur_tag = tag;
        hop_sel = AW'(s);
        repeat (cycles) @(negedge clk);
    endtask

    logic [PW-1:0] vals [N];

    initial begin
        vals[0] = 32'h0100_0000;
        vals[1] = 32'h0123_4567;
        vals[2] = 32'h8000_0001;
        vals[3] = 32'hFFFF_F000;
        vals[4] = 32'h4000_0000;
        vals[5] = 32'h0000_0010;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(phase_out == '0, "R1 phase", phase_out, 0);
        check(sample_out == '0, "R1 sample", sample_out, 0);
        check(bus_readdata == '0, "R1 readdata", bus_readdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_rd(3, '0, "R1 reg cleared");

        cur_tag = "R2";
        for (int i = 0; i < N; i++) bus_wr(i, vals[i]);
        bus_wr(9, 32'hDEAD_BEEF);
        bus_wr(15, 32'hCAFE_F00D);
        bus_rd(9, '0, "R3 out-of-range read");
        bus_rd(15, '0, "R3 out-of-range read");
        for (int i = 0; i < N; i++) bus_rd(i, vals[i], "R2 readback (R3 no alias)");

        // R4: read and write on the same cycle return the old value
        bus_addr      = AW'(5);
        bus_writedata = 32'h0000_0020;
        bus_write     = 1'b1;
        bus_read      = 1'b1;
        @(negedge clk);
        check(bus_readdata == vals[5], "R4 read before write", bus_readdata, vals[5]);
        bus_write = 1'b0;
        bus_read  = 1'b0;
        vals[5]   = 32'h0000_0020;
        @(negedge clk);
        check(bus_readdata == '0, "R4 idle readdata", bus_readdata, 0);
        bus_rd(5, vals[5], "R4 new value");

        for (int s = 0; s < N; s++) hop(s, 7, "R5");
        hop(2, 20, "R6");
        hop(3, 10, "R6");
        hop(0, 3, "R6");

        begin
            logic [PW-1:0] held;
            hop(7, 1, "R7");
            held = phase_out;
            repeat (4) @(negedge clk);
            check(phase_out == held, "R7 hold sel=7", phase_out, held);
            hop(6, 4, "R7");
            check(phase_out == held, "R7 hold sel=6", phase_out, held);
        end

        hop(1, 3, "R8");
        bus_wr(1, 32'h1000_0000);
        repeat (6) @(negedge clk);
        hop(4, 8, "R6");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule